// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Sleep Filter

This block receives asynchronous serial frames on a single input line. It keeps a shift register that fills as a frame arrives and a receive buffer that software reads. Frames carry 7, 8 or 9 data bits, least significant bit first, an optional odd or even parity bit, and one or two stop bits. One bit lasts (n+1)×16 enabled source cycles, where n comes from a divider input and a source enable qualifies each cycle. The divider is held at zero while the line is idle and starts counting when a start edge arrives.

When a frame ends, its data moves into the buffer. At that moment the ready flag sets, the overrun, framing and parity flags are written, and a one-cycle receive interrupt fires if the ready flag was clear. A read strobe, or dropping the enable, clears the ready, overrun, framing and summary flags. A ready/busy output tells the far end when a frame may be sent. In sleep mode, any frame whose top data bit is 0 is dropped, so a node can ignore traffic that is not for it on a shared line.

Top module: `uart_sleep_rx`

## Requirements
- R1: After reset, `rbuf` is 0, `ri`, `oer`, `fer`, `per`, `sum` and `rx_irq` are 0, and `rts` is 1.
- R2: `len_sel` picks the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits and 2'b11 gives 8 bits. Bits arrive least significant first. A transferred frame appears in `rbuf` right-aligned, with the unused upper bits at 0. `rbuf` changes only on a transfer, and a transfer sets `ri`.
- R3: One bit lasts (`div_n`+1)×16 cycles in which `src_en` is 1. Frames sent at that rate are received correctly for several values of `div_n`, including when `src_en` is high only on every other clock.
- R4: When `par_en`=1, a parity bit follows the data. With `par_odd`=0 the data bits plus the parity bit must contain an even number of ones; with `par_odd`=1 they must contain an odd number. On a transfer, `per` is written to 1 on a mismatch and to 0 otherwise. `per` is 0 after a transfer from a frame that has no parity bit.
- R5: On a transfer, `fer` is written to 1 if any configured stop bit (one bit, or two bits when `two_stop`=1) was sampled low, and to 0 otherwise.
- R6: On a transfer, `oer` is written with the value `ri` had just before the transfer. The buffer still takes the new data.
- R7: On a transfer, `sum` is written with the OR of the new `oer`, `fer` and `per`.
- R8: A one-cycle `rd_strobe` with no transfer in the same cycle clears `ri`, `oer`, `fer` and `sum`, and leaves `per` and `rbuf` unchanged. While `rx_en`=0 those same four flags are held at 0.
- R9: `rx_irq` pulses high for exactly one cycle, in the cycle that `ri` rises from 0 to 1. A transfer while `ri` is already 1 gives no pulse.
- R10: When `sleep_en`=1, a frame whose top data bit (bit 6, 7 or 8 for 7, 8 or 9 data bits) is 0 is not transferred: `rbuf`, all flags and `rx_irq` stay unchanged. A frame whose top data bit is 1 is received normally.
- R11: When `rts_en`=1, `rts` is 1 while `rx_en`=0. It is 0 while enabled and idle, 1 from the detected start edge until the frame ends, and 0 again in the cycle the data is transferred. When `rts_en`=0, `rts` stays 1.
- R12: The start bit is confirmed only if the line is still low at its midpoint, 8 sub-bit ticks after the falling edge. A shorter low pulse is discarded without any transfer, and the receiver becomes ready again.
- R13: While `rx_en`=0 the line is ignored: frames sent then cause no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 1 | Qualifies source cycles counted by the bit-rate divider |
| div_n | input | DIV_W | Divider value n; one bit lasts (n+1)×16 enabled cycles |
| len_sel | input | 2 | Data length: 00=7, 01=8, 10=9, 11=8 |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits expected |
| sleep_en | input | 1 | Drop frames whose top data bit is 0 |
| rts_en | input | 1 | Enable the ready/busy output sequence |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | One-cycle pulse when software reads the low byte of the buffer |
| rbuf | output | 9 | Receive buffer, right-aligned |
| ri | output | 1 | Buffer holds unread data |
| oer | output | 1 | Overrun error |
| fer | output | 1 | Framing error |
| per | output | 1 | Parity error |
| sum | output | 1 | Summary error |
| rts | output | 1 | Ready (0) / busy (1) indication |
| rx_irq | output | 1 | One-cycle receive interrupt request |

## Verification
The bench targets the midpoint timing under slow and gated source enables. A divider that counted every clock, or that sampled at an edge, would shift data bits across several `div_n` values. It sends frames with corrupted parity and low first or second stop bits; a design that checked only one stop bit, or inverted the odd/even sense, would write `fer` or `per` wrongly. Back-to-back frames with no read test overrun: the flag must set, the buffer must still update and no second interrupt may fire. Sleep-mode frames with a 0 top bit must leave the buffer and flags untouched for each data length. A short low glitch must be discarded. The ready/busy sequence is probed in the middle of a start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int unsigned MAX_BITS = 9;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP1,
      RX_STOP2
   } rx_state_t;

   typedef struct packed {
      logic [MAX_BITS-1:0] data;
      logic                par_err;
      logic                frm_err;
   } rx_frame_t;

   // number of data bits selected by the length code
   function automatic logic [3:0] len_bits(input logic [1:0] sel);
      case (sel)
         2'b00:   return 4'd7;
         2'b10:   return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign q    = chain[STAGES-1];
   assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_en,
   input  logic [DIV_W-1:0] div_n,
   output logic             sub_tick
);
   logic [DIV_W-1:0] pre;
   logic             wrap;

   assign wrap     = (pre >= div_n);
   assign sub_tick = src_en & ~clr & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre <= '0;
      else if (clr)    pre <= '0;
      else if (src_en) pre <= wrap ? '0 : pre + 1'b1;
   end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int unsigned OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       rx,
   input  logic       fall,
   input  logic       sub_tick,
   input  logic [1:0] len_sel,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       two_stop,
   output logic       baud_clr,
   output logic       busy,
   output logic       done,
   output rx_frame_t  frame
);
   localparam int unsigned OSR_W = $clog2(OSR);
   localparam logic [OSR_W-1:0] HALF_M1 = OSR_W'(OSR/2 - 1);
   localparam logic [OSR_W-1:0] FULL_M1 = OSR_W'(OSR - 1);

   rx_state_t            state;
   logic [OSR_W-1:0]     cnt;
   logic [3:0]           idx;
   logic [3:0]           nb;
   logic [MAX_BITS-1:0]  sh;
   logic                 par_acc;
   logic                 perr;
   logic                 ferr;
   logic                 bit_end;
   logic                 last_stop;

   assign nb        = len_bits(len_sel);
   assign bit_end   = sub_tick & (cnt == FULL_M1);
   assign last_stop = (state == RX_STOP2) | ((state == RX_STOP1) & ~two_stop);
   assign baud_clr  = (state == RX_IDLE);
   assign busy      = (state != RX_IDLE);
   assign done      = en & bit_end & last_stop;

   always_comb begin
      frame.data    = sh >> (4'd9 - nb);
      frame.par_err = perr;
      frame.frm_err = (state == RX_STOP2) ? (ferr | ~rx) : ~rx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         sh      <= '0;
         par_acc <= 1'b0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
      end else if (!en) begin
         state <= RX_IDLE;
      end else begin
         case (state)
            RX_IDLE: begin
               if (fall) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (sub_tick) begin
                  if (cnt == HALF_M1) begin
                     cnt <= '0;
                     if (!rx) begin
                        state   <= RX_DATA;
                        idx     <= '0;
                        par_acc <= 1'b0;
                        perr    <= 1'b0;
                        ferr    <= 1'b0;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (sub_tick) begin
                  if (cnt != FULL_M1) begin
                     cnt <= cnt + 1'b1;
                  end else begin
                     cnt <= '0;
                     case (state)
                        RX_DATA: begin
                           sh      <= {rx, sh[MAX_BITS-1:1]};
                           par_acc <= par_acc ^ rx;
                           if (idx == nb - 4'd1)
                              state <= par_en ? RX_PAR : RX_STOP1;
                           else
                              idx <= idx + 4'd1;
                        end
                        RX_PAR: begin
                           perr  <= par_acc ^ rx ^ par_odd;
                           state <= RX_STOP1;
                        end
                        RX_STOP1: begin
                           ferr  <= ~rx;
                           state <= two_stop ? RX_STOP2 : RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                     endcase
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx
   import uart_rx_pkg::*;
#(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned OSR         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_en,
   input  logic [DIV_W-1:0] div_n,
   input  logic [1:0]       len_sel,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             two_stop,
   input  logic             sleep_en,
   input  logic             rts_en,
   input  logic             rx_en,
   input  logic             rxd,
   input  logic             rd_strobe,
   output logic [8:0]       rbuf,
   output logic             ri,
   output logic             oer,
   output logic             fer,
   output logic             per,
   output logic             sum,
   output logic             rts,
   output logic             rx_irq
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("uart_sleep_rx: DIV_W must be at least 1");
      end
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_sleep_rx: OSR must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_sleep_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      rx_s;
   logic      rx_fall;
   logic      sub_tick;
   logic      baud_clr;
   logic      busy;
   logic      done;
   rx_frame_t frame;
   logic [3:0] nb;
   logic      top_bit;
   logic      xfer;
   logic      new_oer;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rx_s),
      .fall  (rx_fall)
   );

   uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (baud_clr),
      .src_en   (src_en),
      .div_n    (div_n),
      .sub_tick (sub_tick)
   );

   uart_rx_frame #(.OSR(OSR)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .rx       (rx_s),
      .fall     (rx_fall),
      .sub_tick (sub_tick),
      .len_sel  (len_sel),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .two_stop (two_stop),
      .baud_clr (baud_clr),
      .busy     (busy),
      .done     (done),
      .frame    (frame)
   );

   assign nb      = len_bits(len_sel);
   assign top_bit = frame.data[nb - 4'd1];
   assign xfer    = done & ~(sleep_en & ~top_bit);
   assign new_oer = ri;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf   <= '0;
         ri     <= 1'b0;
         oer    <= 1'b0;
         fer    <= 1'b0;
         per    <= 1'b0;
         sum    <= 1'b0;
         rx_irq <= 1'b0;
      end else begin
         rx_irq <= 1'b0;
         if (xfer) begin
            rbuf   <= frame.data;
            ri     <= 1'b1;
            oer    <= new_oer;
            fer    <= frame.frm_err;
            per    <= frame.par_err;
            sum    <= new_oer | frame.frm_err | frame.par_err;
            rx_irq <= ~ri;
         end else if (rd_strobe || !rx_en) begin
            ri  <= 1'b0;
            oer <= 1'b0;
            fer <= 1'b0;
            sum <= 1'b0;
         end
      end
   end

   assign rts = rts_en ? (~rx_en | busy) : 1'b1;
endmodule

// File: rtl/uart_sleep_rx_chk.sv
module uart_sleep_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_en,
   input logic       rts_en,
   input logic [8:0] rbuf,
   input logic       ri,
   input logic       oer,
   input logic       fer,
   input logic       per,
   input logic       sum,
   input logic       rts,
   input logic       rx_irq
);
   AST_BUF_NEEDS_RI: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rbuf) |-> ri);                                   // R2
   AST_OVERRUN_NEEDS_RI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oer) |-> $past(ri));                                // R6
   AST_SUM_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      sum |-> (oer | fer | per));                               // R7
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !ri && !oer && !fer && !sum);                  // R8
   AST_IRQ_ON_RI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> ri && !$past(ri));                             // R9
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);                                      // R9
   AST_RTS_READY_AT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      rts_en && rx_en && $rose(ri) |-> !rts);                   // R11
endmodule

bind uart_sleep_rx uart_sleep_rx_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rx_en  (rx_en),
   .rts_en (rts_en),
   .rbuf   (rbuf),
   .ri     (ri),
   .oer    (oer),
   .fer    (fer),
   .per    (per),
   .sum    (sum),
   .rts    (rts),
   .rx_irq (rx_irq)
);

// File: tb/uart_sleep_rx_bench.sv
module uart_sleep_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_en = 1'b1;
   logic [7:0] div_n = 8'd0;
   logic [1:0] len_sel = 2'b01;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       two_stop = 1'b0;
   logic       sleep_en = 1'b0;
   logic       rts_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       rxd = 1'b1;
   logic       rd_strobe = 1'b0;
   logic [8:0] rbuf;
   logic       ri, oer, fer, per, sum, rts, rx_irq;

   int  n_chk = 0;
   int  n_fail = 0;
   int  irq_cnt = 0;
   int  exp_irq = 0;
   bit  gate = 1'b0;
   bit  done_run = 1'b0;

   logic [8:0] m_buf = '0;
   logic       m_ri = 0, m_oer = 0, m_fer = 0, m_per = 0, m_sum = 0;

   always #4 clk = ~clk;

   uart_sleep_rx u_uart_sleep_rx (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .div_n(div_n),
      .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
      .two_stop(two_stop), .sleep_en(sleep_en), .rts_en(rts_en),
      .rx_en(rx_en), .rxd(rxd), .rd_strobe(rd_strobe), .rbuf(rbuf),
      .ri(ri), .oer(oer), .fer(fer), .per(per), .sum(sum), .rts(rts),
      .rx_irq(rx_irq)
   );

   always @(negedge clk) src_en <= gate ? ~src_en : 1'b1;
   always @(negedge clk) if (rx_irq === 1'b1) irq_cnt++;

   function automatic int nbits(input logic [1:0] s);
      return (s == 2'b00) ? 7 : (s == 2'b10) ? 9 : 8;
   endfunction

   function automatic logic [8:0] lmask(input logic [1:0] s);
      return 9'h1FF >> (9 - nbits(s));
   endfunction

   function automatic int bit_cyc();
      return (int'(div_n) + 1) * 16 * (gate ? 2 : 1);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bit_out(input logic v);
      rxd = v;
      repeat (bit_cyc()) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] d, input bit bad_par,
                       input bit bad_s1, input bit bad_s2, input bit probe);
      logic pb;
      pb = (^(d & lmask(len_sel))) ^ par_odd;
      rxd = 1'b0;
      if (probe) begin
         repeat (6) @(negedge clk);
         chk("R11 rts busy in start bit", rts, 1);
         repeat (bit_cyc() - 6) @(negedge clk);
      end else begin
         repeat (bit_cyc()) @(negedge clk);
      end
      for (int i = 0; i < nbits(len_sel); i++) bit_out(d[i]);
      if (par_en) bit_out(pb ^ bad_par);
      bit_out(~bad_s1);
      if (two_stop) bit_out(~bad_s2);
      rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   // expected state update for one frame, then compare all outputs
   task automatic frame_check(input logic [8:0] d, input bit bad_par,
                              input bit bad_s1, input bit bad_s2, input string tag);
      logic [8:0] md;
      md = d & lmask(len_sel);
      if (!(sleep_en && !md[nbits(len_sel)-1])) begin
         if (!m_ri) exp_irq++;
         m_oer = m_ri;
         m_ri  = 1'b1;
         m_buf = md;
         m_fer = bad_s1 | (two_stop & bad_s2);
         m_per = par_en & bad_par;
         m_sum = m_oer | m_fer | m_per;
      end
      chk({tag, " R2 rbuf"}, rbuf, m_buf);
      chk({tag, " R2 ri"}, ri, m_ri);
      chk({tag, " R4 per"}, per, m_per);
      chk({tag, " R5 fer"}, fer, m_fer);
      chk({tag, " R6 oer"}, oer, m_oer);
      chk({tag, " R7 sum"}, sum, m_sum);
      chk({tag, " R9 irq count"}, irq_cnt, exp_irq);
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
      m_ri = 0; m_oer = 0; m_fer = 0; m_sum = 0;
      chk("R8 ri after read", ri, 0);
      chk("R8 sum after read", sum, 0);
      chk("R8 per kept", per, m_per);
      chk("R8 rbuf kept", rbuf, m_buf);
   endtask

   task automatic txf(input logic [8:0] d, input bit bp, input bit b1,
                      input bit b2, input string tag);
      send(d, bp, b1, b2, 1'b0);
      frame_check(d, bp, b1, b2, tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rbuf", rbuf, 0);
      chk("R1 flags", {ri, oer, fer, per, sum, rx_irq}, 0);
      chk("R1 rts", rts, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 ready/busy sequence
      rts_en = 1'b1; div_n = 8'd1;
      @(negedge clk);
      chk("R11 rts while disabled", rts, 1);
      rx_en = 1'b1;
      @(negedge clk);
      chk("R11 rts ready", rts, 0);
      send(9'h0A5, 0, 0, 0, 1'b1);
      frame_check(9'h0A5, 0, 0, 0, "rts");
      chk("R11 rts ready after transfer", rts, 0);
      do_read();

      // R12 short glitch is discarded
      rxd = 1'b0;
      repeat (3) @(negedge clk);
      rxd = 1'b1;
      repeat (60) @(negedge clk);
      chk("R12 glitch no transfer", ri, 0);
      chk("R12 glitch rbuf kept", rbuf, m_buf);
      chk("R12 rts ready again", rts, 0);

      // R13 disabled receiver ignores line, R8 disable clears
      txf(9'h03C, 0, 0, 0, "pre-dis");
      rx_en = 1'b0;
      @(negedge clk);
      m_ri = 0; m_oer = 0; m_fer = 0; m_sum = 0;
      chk("R8 ri cleared by disable", ri, 0);
      chk("R11 rts high when disabled", rts, 1);
      send(9'h0FF, 0, 0, 0, 1'b0);
      chk("R13 no transfer while disabled", ri, 0);
      chk("R13 rbuf kept", rbuf, m_buf);
      rx_en = 1'b1; rts_en = 1'b0;
      @(negedge clk);
      chk("R11 rts off", rts, 1);

      // R6 / R9 overrun with back-to-back frames
      txf(9'h011, 0, 0, 0, "ovr1");
      txf(9'h0E2, 0, 0, 0, "ovr2 R6");
      chk("R6 oer set", oer, 1);
      do_read();

      // R10 sleep mode, all lengths
      sleep_en = 1'b1;
      for (int l = 0; l < 3; l++) begin
         len_sel = 2'(l);
         txf(9'h000 | (9'h1 << 2), 0, 0, 0, "R10 drop");
         chk("R10 dropped frame leaves ri", ri, m_ri);
         txf(lmask(len_sel) & ~9'h1, 0, 0, 0, "R10 accept");
         do_read();
      end
      sleep_en = 1'b0;

      // R3 gated source enable, several dividers
      gate = 1'b1;
      for (int k = 0; k < 3; k++) begin
         div_n = 8'(k);
         len_sel = 2'b10;
         txf(9'h15A ^ 9'(k * 37), 0, 0, 0, "R3 gated");
         do_read();
      end
      gate = 1'b0;

      // R4 / R5 directed parity and stop-bit faults
      len_sel = 2'b01; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b1; div_n = 8'd0;
      txf(9'h0C3, 1, 0, 0, "R4 odd bad");
      txf(9'h0C3, 0, 0, 1, "R5 second stop low");
      do_read();
      len_sel = 2'b11; par_odd = 1'b0;
      txf(9'h07E, 0, 1, 0, "R5 first stop low");
      do_read();

      // constrained random frames
      for (int it = 0; it < 48; it++) begin
         bit bp, b1, b2;
         logic [8:0] d;
         len_sel  = 2'($urandom % 4);
         par_en   = 1'($urandom);
         par_odd  = 1'($urandom);
         two_stop = 1'($urandom);
         div_n    = 8'($urandom % 3);
         sleep_en = ($urandom % 4) == 0;
         bp = ($urandom % 6) == 0;
         b1 = ($urandom % 8) == 0;
         b2 = ($urandom % 8) == 0;
         d  = 9'($urandom);
         if (b1) repeat (bit_cyc()) @(negedge clk);
         txf(d, bp, b1, b2, "rand");
         if ($urandom % 2) do_read();
      end

      done_run = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_run) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule